// File: doc/BRIEF.md
# Aligned Write Data Staging FIFO

This block sits between a user application that produces outbound write data and a bus master engine that drives it onto a 32-bit or 64-bit system bus. The application pushes one 32-bit word per cycle, along with four byte enables and an end-of-transfer marker. The block packs consecutive words into 64-bit slots so that every transfer begins on a 64-bit boundary. It reports how much room is left through two active-low flags.

On the read side, the engine sees one whole slot per read when the bus is 64 bits wide. When the bus is 32 bits wide, it sees one word per read, and words whose byte enables are all zero are skipped. The application is responsible for the leading padding word of bursts, and of any 64-bit transfer, that start at an odd 32-bit address. For a lone word on a 32-bit bus with an odd start address, the block does the alignment itself.

Top module: `write_stage_fifo`

## Requirements
- R1: After reset the FIFO is empty: `full_n` = 1, `afull_n` = 1 and `rd_valid` = 0.
- R2: Each cycle with `wr_en_n` low stores `wr_data`, `wr_be` and the marker (`wr_last_n` low means last). Words are read out in the order they were written. In 64-bit mode, two consecutive words of one transfer share a slot: the first goes to bits [31:0] (enables [3:0]) and the second to bits [63:32] (enables [7:4]).
- R3: The FIFO holds 32 slots (64 words). `full_n` goes low when all 64 word positions are filled, as seen right after the clock edge that stores the last word. The application never writes while `full_n` is low.
- R4: A slot counts as used once its first word is written. `afull_n` is low whenever 4 or fewer slots are unused.
- R5: Reads and writes may occur in the same cycle. Data order is kept, and the flags follow the resulting occupancy in either direction.
- R6: If the last word of a transfer lands in the low half of a slot, the block closes that slot with a high half of data 0, enables 0 and marker 0. The next transfer starts in a fresh slot.
- R7: With `cfg_bus64` = 0, a word whose four byte enables are all zero is never presented. A slot holding only such words is dropped. Presented words appear on `rd_data[31:0]` and `rd_be[3:0]`, with the upper halves at zero.
- R8: With `cfg_bus64` = 1, both halves of a slot are presented together, including any half with all-zero enables. `rd_last` is the OR of the two halves' markers.
- R9: With `cfg_bus64` = 0, a transfer whose first word is also its last needs no padding word, whatever the state of `cfg_odd_start`. That word is presented exactly once, with `rd_last` = 1.
- R10: `wr_last_n` held low while `wr_en_n` is high stores nothing, changes no flag, and does not end the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_bus64 | input | 1 | 1: read side is 64 bits wide; 0: 32 bits wide (change only when empty) |
| cfg_odd_start | input | 1 | Transfer start address is at an odd 32-bit word |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_last_n | input | 1 | Active-low last-word marker |
| wr_data | input | 32 | Write data word |
| wr_be | input | 4 | Byte enables of the word |
| full_n | output | 1 | Active-low full flag |
| afull_n | output | 1 | Active-low almost-full flag |
| rd_en | input | 1 | Engine takes the presented item this cycle |
| rd_valid | output | 1 | An item is presented |
| rd_data | output | 64 | Presented data |
| rd_be | output | 8 | Presented byte enables |
| rd_last | output | 1 | Presented item ends a transfer |

## Verification
The hardest situations to reach are the slot layouts that only unusual write sequences produce. One is a slot made entirely of zero-enable words, which must vanish in 32-bit mode with no read request. Another is a transfer ending in a low half while the next one begins right behind it. The bench builds these with explicit sequences: an odd-start burst with its leading pad, two pads followed by a lone last word, and an odd-length burst followed at once by another transfer. It also fills all 64 positions with reads held off, so that the almost-full boundary at 28 used slots and the full boundary can be seen word by word. Then it drains the FIFO and streams data with reads and writes overlapping.

// File: rtl/wsf_pkg.sv
`timescale 1ns/1ps
package wsf_pkg;
  parameter int WORD_W = 32;
  localparam int BE_W = WORD_W / 8;

  typedef struct packed {
    logic              last;
    logic [BE_W-1:0]   be;
    logic [WORD_W-1:0] data;
  } half_t;

  typedef struct packed {
    half_t hi;
    half_t lo;
  } slot_t;

  localparam half_t FILL_HALF = '0;
endpackage

// File: rtl/wsf_packer.sv
`timescale 1ns/1ps
module wsf_packer
  import wsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus64,
  input  logic              cfg_odd_start,
  input  logic              wr_en_n,
  input  logic              wr_last_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic              push,
  output slot_t             push_slot,
  output logic              half_open
);
  logic  open_q, open_d;
  logic  inxfer_q, inxfer_d;
  logic  lo_load;
  half_t lo_q;
  half_t word;
  logic  wr;

  assign wr   = ~wr_en_n;
  assign word = '{last: ~wr_last_n, be: wr_be, data: wr_data};

  always_comb begin
    open_d    = open_q;
    inxfer_d  = inxfer_q;
    lo_load   = 1'b0;
    push      = 1'b0;
    push_slot = '{hi: FILL_HALF, lo: FILL_HALF};
    if (wr) begin
      inxfer_d = ~word.last;
      if (open_q) begin
        push         = 1'b1;
        push_slot.lo = lo_q;
        push_slot.hi = word;
        open_d       = 1'b0;
      end else if (word.last) begin
        push = 1'b1;
        if (!inxfer_q && !cfg_bus64 && cfg_odd_start) push_slot.hi = word;
        else                                          push_slot.lo = word;
      end else begin
        open_d  = 1'b1;
        lo_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      inxfer_q <= 1'b0;
    end else begin
      open_q   <= open_d;
      inxfer_q <= inxfer_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lo_load) lo_q <= word;
  end

  assign half_open = open_q;
endmodule

// File: rtl/wsf_store.sv
`timescale 1ns/1ps
module wsf_store
  import wsf_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int PTR_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  slot_t            push_slot,
  input  logic             pop,
  output slot_t            head,
  output logic [CNT_W-1:0] count
);
  slot_t            mem [SLOTS];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? wp_q + PTR_W'(1) : wp_q;
    rp_d  = pop  ? rp_q + PTR_W'(1) : rp_q;
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_slot;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/wsf_unpack.sv
`timescale 1ns/1ps
module wsf_unpack
  import wsf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_bus64,
  input  logic                has_slot,
  input  slot_t               head,
  input  logic                rd_en,
  output logic                pop,
  output logic                rd_valid,
  output logic [2*WORD_W-1:0] rd_data,
  output logic [2*BE_W-1:0]   rd_be,
  output logic                rd_last
);
  logic  hsel_q, hsel_d;
  logic  lo_pad, hi_pad, eff_hi, take, drop;
  half_t sel;

  assign lo_pad = (head.lo.be == '0);
  assign hi_pad = (head.hi.be == '0);
  assign eff_hi = hsel_q | lo_pad;
  assign sel    = eff_hi ? head.hi : head.lo;

  always_comb begin
    hsel_d = hsel_q;
    take   = 1'b0;
    drop   = 1'b0;
    if (cfg_bus64) begin
      rd_valid = has_slot;
      rd_data  = {head.hi.data, head.lo.data};
      rd_be    = {head.hi.be, head.lo.be};
      rd_last  = head.hi.last | head.lo.last;
      pop      = has_slot & rd_en;
      hsel_d   = 1'b0;
    end else begin
      rd_valid = has_slot & ~(eff_hi & hi_pad);
      rd_data  = {{WORD_W{1'b0}}, sel.data};
      rd_be    = {{BE_W{1'b0}}, sel.be};
      rd_last  = sel.last;
      take     = rd_valid & rd_en;
      drop     = has_slot & eff_hi & hi_pad;
      pop      = drop | (take & (eff_hi | hi_pad));
      if (pop)       hsel_d = 1'b0;
      else if (take) hsel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hsel_q <= 1'b0;
    else        hsel_q <= hsel_d;
  end
endmodule

// File: rtl/write_stage_fifo.sv
`timescale 1ns/1ps
module write_stage_fifo
  import wsf_pkg::*;
#(
  parameter int SLOTS      = 32,
  parameter int AFULL_FREE = 4,
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_bus64,
  input  logic                cfg_odd_start,
  input  logic                wr_en_n,
  input  logic                wr_last_n,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [BE_W-1:0]     wr_be,
  output logic                full_n,
  output logic                afull_n,
  input  logic                rd_en,
  output logic                rd_valid,
  output logic [2*WORD_W-1:0] rd_data,
  output logic [2*BE_W-1:0]   rd_be,
  output logic                rd_last
);
  logic             push, pop, half_open;
  slot_t            push_slot, head;
  logic [CNT_W-1:0] count, free_slots;

  wsf_packer u_pack (
    .clk, .rst_n, .cfg_bus64, .cfg_odd_start,
    .wr_en_n, .wr_last_n, .wr_data, .wr_be,
    .push, .push_slot, .half_open
  );

  wsf_store #(.SLOTS(SLOTS)) u_store (
    .clk, .rst_n, .push, .push_slot, .pop, .head, .count
  );

  wsf_unpack u_unpack (
    .clk, .rst_n, .cfg_bus64, .has_slot(count != '0), .head, .rd_en,
    .pop, .rd_valid, .rd_data, .rd_be, .rd_last
  );

  assign free_slots = CNT_W'(SLOTS) - count - CNT_W'(half_open);
  assign full_n     = ~(count == CNT_W'(SLOTS));
  assign afull_n    = ~(free_slots <= CNT_W'(AFULL_FREE));
endmodule

// File: rtl/wsf_checker.sv
`timescale 1ns/1ps
module wsf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_bus64,
  input logic        wr_en_n,
  input logic        full_n,
  input logic        afull_n,
  input logic        rd_en,
  input logic        rd_valid,
  input logic [63:0] rd_data,
  input logic [7:0]  rd_be
);
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (full_n && afull_n && !rd_valid));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> wr_en_n);

  p_full_in_afull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bus64 && rd_valid && !rd_en) |=> (!cfg_bus64 || (rd_valid && $stable(rd_data) && $stable(rd_be))));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bus64 && wr_en_n && !rd_en) |=> ($stable(full_n) && $stable(afull_n)));

  p_pad_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_bus64 && rd_valid) |-> (rd_be[3:0] != 4'h0 && rd_be[7:4] == 4'h0));
endmodule

bind write_stage_fifo wsf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bus64(cfg_bus64), .wr_en_n(wr_en_n),
  .full_n(full_n), .afull_n(afull_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_be(rd_be)
);

// File: tb/tb_write_stage_fifo.sv
`timescale 1ns/1ps
module tb_write_stage_fifo;
  logic        clk = 1'b0;
  logic        rst_n, cfg_bus64, cfg_odd_start, wr_en_n, wr_last_n, rd_en;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        full_n, afull_n, rd_valid, rd_last;
  logic [63:0] rd_data;
  logic [7:0]  rd_be;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [72:0] exp_q [$];
  logic        m_open;
  logic [36:0] m_lo;

  always #2 clk = ~clk;

  write_stage_fifo dut (
    .clk, .rst_n, .cfg_bus64, .cfg_odd_start, .wr_en_n, .wr_last_n,
    .wr_data, .wr_be, .full_n, .afull_n, .rd_en, .rd_valid,
    .rd_data, .rd_be, .rd_last
  );

  task automatic check(input string req, input logic [72:0] act, input logic [72:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual=%h expected=none", {rd_last, rd_be, rd_data});
      end else begin
        check("R2 read item", {rd_last, rd_be, rd_data}, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver: one write, expected items pushed per the requirements
  task automatic wr_word(input logic [31:0] d, input logic [3:0] be, input logic last);
    wr_en_n = 1'b0; wr_last_n = ~last; wr_data = d; wr_be = be;
    if (cfg_bus64) begin
      if (m_open) begin
        exp_q.push_back({last | m_lo[36], be, m_lo[35:32], d, m_lo[31:0]});
        m_open = 1'b0;
      end else if (last) begin
        exp_q.push_back({1'b1, 4'h0, be, 32'h0, d});
      end else begin
        m_lo = {last, be, d}; m_open = 1'b1;
      end
    end else if (be != 4'h0) begin
      exp_q.push_back({last, 4'h0, be, 32'h0, d});
    end
    @(posedge clk); #1;
    wr_en_n = 1'b1; wr_last_n = 1'b1;
  endtask

  task automatic drain();
    rd_en = 1'b1;
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
    repeat (3) @(posedge clk);
    #1;
    check("R2 drained, nothing left", {72'h0, rd_valid}, 73'h0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_bus64 = 1'b1; cfg_odd_start = 1'b0; wr_en_n = 1'b1;
    wr_last_n = 1'b1; rd_en = 1'b0; wr_data = '0; wr_be = '0;
    m_open = 1'b0; m_lo = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset flags/valid", {70'h0, full_n, afull_n, rd_valid}, {70'h0, 3'b110});

    // R3 / R4: fill 64 words with reads held off
    for (int k = 1; k <= 64; k++) begin
      wr_word(32'hA000_0000 + k, 4'hF, k == 64);
      check("R4 afull_n during fill", {72'h0, afull_n}, {72'h0, ((k + 1) / 2) < 28});
      check("R3 full_n during fill", {72'h0, full_n}, {72'h0, k < 64});
    end
    drain();
    check("R3 flags after drain", {71'h0, full_n, afull_n}, {71'h0, 2'b11});

    // R5: reads and writes overlapping
    rd_en = 1'b1;
    for (int k = 0; k < 21; k++) wr_word(32'hB000_0000 + k, 4'h3 + k[3:0], k == 20);
    drain();
    check("R5 flags empty after stream", {71'h0, full_n, afull_n}, {71'h0, 2'b11});

    // R6: odd-length burst closed with fill half, then a fresh transfer
    rd_en = 1'b0;
    wr_word(32'h6000_0001, 4'hF, 1'b0);
    wr_word(32'h6000_0002, 4'h1, 1'b0);
    wr_word(32'h6000_0003, 4'h8, 1'b1);
    wr_word(32'h6000_0004, 4'hF, 1'b0);
    wr_word(32'h6000_0005, 4'hC, 1'b1);
    drain();

    // R8: 64-bit odd-start burst with application pad, pad half presented
    cfg_odd_start = 1'b1;
    wr_word(32'h0, 4'h0, 1'b0);
    wr_word(32'h8000_0001, 4'hF, 1'b0);
    wr_word(32'h8000_0002, 4'hF, 1'b0);
    wr_word(32'h8000_0003, 4'h7, 1'b1);
    drain();

    // R10: last marker without write enable
    rd_en = 1'b0; wr_last_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 nothing stored", {70'h0, rd_valid, full_n, afull_n}, {70'h0, 3'b011});
    wr_last_n = 1'b1;
    wr_word(32'h1000_0001, 4'hF, 1'b0);
    wr_word(32'h1000_0002, 4'hF, 1'b1);
    drain();

    // R7: 32-bit bus, odd-start burst with pad, then an all-pad slot
    cfg_bus64 = 1'b0;
    wr_word(32'h0, 4'h0, 1'b0);
    wr_word(32'h7000_0001, 4'hF, 1'b0);
    wr_word(32'h7000_0002, 4'h2, 1'b0);
    wr_word(32'h7000_0003, 4'hF, 1'b1);
    wr_word(32'h0, 4'h0, 1'b0);
    wr_word(32'h0, 4'h0, 1'b0);
    wr_word(32'h7000_0004, 4'h9, 1'b1);
    drain();

    // R9: single-word transfers on 32-bit bus, odd and even starts
    wr_word(32'h9000_0001, 4'hF, 1'b1);
    cfg_odd_start = 1'b0;
    wr_word(32'h9000_0002, 4'h5, 1'b1);
    cfg_odd_start = 1'b1;
    wr_word(32'h9000_0003, 4'hE, 1'b1);
    drain();
    check("R9 flags empty", {71'h0, full_n, afull_n}, {71'h0, 2'b11});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule